// File: doc/BRIEF.md
# PWM Timer Bank with Complementary Dead-Time Output

This block holds a set of independent 16-bit down-counting timers. Each one produces a pulse-width-modulated output whose period, duty and polarity are set through a single write port. All channels share one count source. This source is either a programmable divider of the system clock or an external clock pin. Each channel selects its source on its own. When a channel finishes a period, it emits a one-cycle request. The request goes to the interrupt line or to the DMA line of that channel, whichever is selected.

Period and compare values are written into holding registers. The counter picks them up only when it starts or reloads, so a waveform never shows a partly updated period. A channel either repeats its period or runs once and then parks with its output inactive. Channel 0 also feeds a complementary pair of outputs. After every change of channel 0's level, both outputs of the pair are held low for a programmable number of divider ticks, so that two switches driven by the pair never conduct together.

Top module: `pwm_timer_bank`

## Requirements
- R1: After synchronous reset, every `pwm_o` bit, `irq_o`, `dma_req_o` and `dz_p_o` are low, and `dz_n_o` is high.
- R2: The divider emits a tick on one clock out of every DIV+1, where DIV is field [7:0] of the global register.
- R3: A started channel loads its period value P and counts down by one on each count tick. After the tick that finds zero, it has spent P+1 ticks in the period. Its raw level is high while it is running and its count is less than or equal to its active compare value.
- R4: Control bit 2 inverts the channel output. The inversion also applies while the channel is idle, so an idle inverted channel drives high.
- R5: Period and compare writes go to holding registers. They reach the counter only when the channel starts or reloads at the end of a period.
- R6: With control bit 1 set, the channel reloads and repeats. With bit 1 clear, it stops after its zero tick, and its output returns to the inactive level.
- R7: The cycle after the zero tick, a one-cycle pulse appears on `irq_o[ch]` if control bit 4 is 0, or on `dma_req_o[ch]` if bit 4 is 1, never on both.
- R8: With control bit 3 set, a channel counts once per rising edge of `ext_clk_i`. The edge is taken after two synchronising flip-flops.
- R9: Each time channel 0's output level changes, both `dz_p_o` and `dz_n_o` are held low until DZ divider ticks have passed, where DZ is field [15:8] of the global register. Otherwise `dz_p_o` follows the level and `dz_n_o` its inverse, one cycle later.
- R10: Write port register select: 0 is period, 1 is compare, 2 is control (bit 0 is run), 3 is global (`wr_ch` is ignored). Writing control with bit 0 set starts an idle channel. Writing it with bit 0 clear stops the channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_reg | input | 2 | Register select (see R10) |
| wr_data | input | 16 | Write data |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| pwm_o | output | 4 | Per-channel PWM outputs |
| dz_p_o | output | 1 | Channel 0 true output with dead time |
| dz_n_o | output | 1 | Channel 0 complementary output with dead time |
| irq_o | output | 4 | Per-channel end-of-period interrupt pulse |
| dma_req_o | output | 4 | Per-channel end-of-period DMA request pulse |

## Verification
A count tick acts at a clock edge, and the new PWM level is visible in the cycle right after that edge. The end-of-period pulse appears in that same following cycle. The dead-time pair lags channel 0 by one more cycle. An external rising edge moves the counter only at the third clock edge after it, because it passes two synchronising stages and an edge-detect stage. The bench drives inputs on falling edges and advances its behavioural model on rising edges. It compares every output against that model on the next falling edge, so each expected value is sampled in exactly the cycle it is due. Directed window counts add checks of duty, pulse rate and one-shot stop that do not depend on the model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_CMP    = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_GLOBAL = 2'd3
    } reg_sel_e;

    // packed MSB first: dma_sel is bit 4, run is bit 0
    typedef struct packed {
        logic dma_sel;
        logic ext_sel;
        logic invert;
        logic autoreload;
        logic run;
    } ch_ctrl_t;

    localparam int CTRL_W = $bits(ch_ctrl_t);

    function automatic ch_ctrl_t to_ctrl(input logic [CTRL_W-1:0] bits);
        return ch_ctrl_t'(bits);
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [PSW-1:0] div_val,
    input  logic           ext_in,
    output logic           div_tick,
    output logic           ext_tick
);
    logic [PSW-1:0] div_cnt;
    logic [2:0]     ext_sync;

    assign div_tick = (div_cnt >= div_val);
    assign ext_tick = ext_sync[1] & ~ext_sync[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt  <= '0;
            ext_sync <= '0;
        end else begin
            div_cnt  <= div_tick ? '0 : div_cnt + 1'b1;
            ext_sync <= {ext_sync[1:0], ext_in};
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_period,
    input  logic          wr_cmp,
    input  logic          wr_ctrl,
    input  logic [CW-1:0] wr_data,
    input  logic          div_tick,
    input  logic          ext_tick,
    output logic          pwm_o,
    output logic          irq_o,
    output logic          dma_o,
    output logic          running_o,
    output logic          invert_o
);
    logic [CW-1:0] period_buf, cmp_buf, cmp_act, cnt;
    ch_ctrl_t      ctrl, ctrl_new;
    logic          running, step;

    assign ctrl_new  = to_ctrl(wr_data[CTRL_W-1:0]);
    assign step      = ctrl.ext_sel ? ext_tick : div_tick;
    assign pwm_o     = (running && (cnt <= cmp_act)) ^ ctrl.invert;
    assign running_o = running;
    assign invert_o  = ctrl.invert;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_buf <= '0;
            cmp_buf    <= '0;
            cmp_act    <= '0;
            cnt        <= '0;
            ctrl       <= '0;
            running    <= 1'b0;
            irq_o      <= 1'b0;
            dma_o      <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            dma_o <= 1'b0;
            if (wr_ctrl && !ctrl_new.run) begin
                running <= 1'b0;
            end else if (wr_ctrl && ctrl_new.run && !running) begin
                running <= 1'b1;
                cnt     <= period_buf;
                cmp_act <= cmp_buf;
            end else if (running && step) begin
                if (cnt == '0) begin
                    irq_o <= ~ctrl.dma_sel;
                    dma_o <= ctrl.dma_sel;
                    if (ctrl.autoreload) begin
                        cnt     <= period_buf;
                        cmp_act <= cmp_buf;
                    end else begin
                        running <= 1'b0;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (wr_period) period_buf <= wr_data;
            if (wr_cmp)    cmp_buf    <= wr_data;
            if (wr_ctrl)   ctrl       <= ctrl_new;
        end
    end
endmodule

// File: rtl/pwm_deadzone.sv
module pwm_deadzone #(
    parameter int DZW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           level_i,
    input  logic [DZW-1:0] dz_val,
    input  logic           tick,
    output logic           p_o,
    output logic           n_o
);
    logic           level_q;
    logic [DZW-1:0] hold;
    logic           quiet;

    assign quiet = (hold == '0);
    assign p_o   = quiet &  level_q;
    assign n_o   = quiet & ~level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            hold    <= '0;
        end else if (level_i != level_q) begin
            level_q <= level_i;
            hold    <= dz_val;
        end else if (!quiet && tick) begin
            hold <= hold - 1'b1;
        end
    end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PSW = 8,
    parameter int DZW = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [1:0]     wr_reg,
    input  logic [CW-1:0]  wr_data,
    input  logic           ext_clk_i,
    output logic [NCH-1:0] pwm_o,
    output logic           dz_p_o,
    output logic           dz_n_o,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] dma_req_o
);
    logic [PSW-1:0] div_val;
    logic [DZW-1:0] dz_val;
    logic           div_tick, ext_tick;
    logic [NCH-1:0] ch_running, ch_invert;
    reg_sel_e       sel;

    assign sel = reg_sel_e'(wr_reg);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_val <= '0;
            dz_val  <= '0;
        end else if (wr_en && sel == SEL_GLOBAL) begin
            div_val <= wr_data[PSW-1:0];
            dz_val  <= wr_data[PSW+DZW-1:PSW];
        end
    end

    pwm_tick_gen #(.PSW(PSW)) u_tick (
        .clk(clk), .rst(rst), .div_val(div_val), .ext_in(ext_clk_i),
        .div_tick(div_tick), .ext_tick(ext_tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CHW'(i));
        pwm_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst(rst),
            .wr_period(hit && sel == SEL_PERIOD),
            .wr_cmp(hit && sel == SEL_CMP),
            .wr_ctrl(hit && sel == SEL_CTRL),
            .wr_data(wr_data),
            .div_tick(div_tick), .ext_tick(ext_tick),
            .pwm_o(pwm_o[i]), .irq_o(irq_o[i]), .dma_o(dma_req_o[i]),
            .running_o(ch_running[i]), .invert_o(ch_invert[i])
        );
    end

    pwm_deadzone #(.DZW(DZW)) u_dz (
        .clk(clk), .rst(rst), .level_i(pwm_o[0]), .dz_val(dz_val),
        .tick(div_tick), .p_o(dz_p_o), .n_o(dz_n_o)
    );
endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk #(
    parameter int NCH = 4,
    parameter int PSW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [1:0]     wr_reg,
    input logic [NCH-1:0] pwm_o,
    input logic           dz_p_o,
    input logic           dz_n_o,
    input logic [NCH-1:0] irq_o,
    input logic [NCH-1:0] dma_req_o,
    input logic           div_tick,
    input logic [PSW-1:0] div_val,
    input logic           ext_tick,
    input logic [NCH-1:0] ch_running,
    input logic [NCH-1:0] ch_invert
);
    AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
        (div_tick && div_val != '0 && !(wr_en && wr_reg == 2'd3)) |=> !div_tick); // R2

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ((~ch_running & (pwm_o ^ ch_invert)) == '0)); // R6

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & dma_req_o) == '0)); // R7

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ext_tick |=> !ext_tick); // R8

    AST_DZ_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(dz_p_o && dz_n_o)); // R9
endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(.NCH(NCH), .PSW(PSW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_reg(wr_reg), .pwm_o(pwm_o),
    .dz_p_o(dz_p_o), .dz_n_o(dz_n_o), .irq_o(irq_o), .dma_req_o(dma_req_o),
    .div_tick(div_tick), .div_val(div_val), .ext_tick(ext_tick),
    .ch_running(ch_running), .ch_invert(ch_invert)
);

// File: tb/pwm_timer_bank_test.sv
`timescale 1ns/1ps
module pwm_timer_bank_test;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [1:0]  wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic        ext_clk_i = 1'b0;
    logic [3:0]  pwm_o, irq_o, dma_req_o;
    logic        dz_p_o, dz_n_o;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pwm_timer_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_reg(wr_reg),
        .wr_data(wr_data), .ext_clk_i(ext_clk_i), .pwm_o(pwm_o),
        .dz_p_o(dz_p_o), .dz_n_o(dz_n_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    // behavioural reference model
    int m_per[NCH], m_cmpb[NCH], m_cmpa[NCH], m_cnt[NCH];
    bit m_run[NCH], m_auto[NCH], m_inv[NCH], m_ext[NCH], m_dsel[NCH];
    bit m_irq[NCH], m_dma[NCH];
    int m_div, m_divc, m_dzv, m_dzc;
    bit m_lq, m_e1, m_e2, m_e3;

    function automatic bit exp_level(int i);
        return (m_run[i] && (m_cnt[i] <= m_cmpa[i])) ^ m_inv[i];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_per[i] = 0; m_cmpb[i] = 0; m_cmpa[i] = 0; m_cnt[i] = 0;
                m_run[i] = 0; m_auto[i] = 0; m_inv[i] = 0; m_ext[i] = 0;
                m_dsel[i] = 0; m_irq[i] = 0; m_dma[i] = 0;
            end
            m_div = 0; m_divc = 0; m_dzv = 0; m_dzc = 0;
            m_lq = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0;
        end else begin
            bit tick, et, l0;
            tick = (m_divc >= m_div);
            et   = m_e2 && !m_e3;
            l0   = exp_level(0);
            if (l0 != m_lq) begin
                m_lq = l0; m_dzc = m_dzv;
            end else if (m_dzc != 0 && tick) begin
                m_dzc--;
            end
            m_divc = tick ? 0 : m_divc + 1;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk_i;
            for (int i = 0; i < NCH; i++) begin
                bit sel, en, cw;
                sel = wr_en && (int'(wr_ch) == i);
                cw  = sel && wr_reg == 2;
                en  = m_ext[i] ? et : tick;
                m_irq[i] = 0; m_dma[i] = 0;
                if (cw && !wr_data[0]) m_run[i] = 0;
                else if (cw && wr_data[0] && !m_run[i]) begin
                    m_run[i] = 1; m_cnt[i] = m_per[i]; m_cmpa[i] = m_cmpb[i];
                end else if (m_run[i] && en) begin
                    if (m_cnt[i] == 0) begin
                        if (m_dsel[i]) m_dma[i] = 1; else m_irq[i] = 1;
                        if (m_auto[i]) begin
                            m_cnt[i] = m_per[i]; m_cmpa[i] = m_cmpb[i];
                        end else m_run[i] = 0;
                    end else m_cnt[i]--;
                end
                if (sel && wr_reg == 0) m_per[i] = int'(wr_data);
                if (sel && wr_reg == 1) m_cmpb[i] = int'(wr_data);
                if (cw) begin
                    m_auto[i] = wr_data[1]; m_inv[i] = wr_data[2];
                    m_ext[i] = wr_data[3]; m_dsel[i] = wr_data[4];
                end
            end
            if (wr_en && wr_reg == 3) begin
                m_div = int'(wr_data[7:0]); m_dzv = int'(wr_data[15:8]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // lockstep comparison on every falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            logic [3:0] ep, ei, ed;
            for (int i = 0; i < NCH; i++) begin
                ep[i] = exp_level(i); ei[i] = m_irq[i]; ed[i] = m_dma[i];
            end
            check(pwm_o == ep, "R3 pwm level", pwm_o, ep);
            check(irq_o == ei, "R7 irq pulse", irq_o, ei);
            check(dma_req_o == ed, "R7 dma pulse", dma_req_o, ed);
            check({dz_p_o, dz_n_o} == {(m_dzc == 0) && m_lq, (m_dzc == 0) && !m_lq},
                  "R9 dead-time pair", {dz_p_o, dz_n_o},
                  {(m_dzc == 0) && m_lq, (m_dzc == 0) && !m_lq});
        end
    end

    task automatic wr(input int r, input int ch, input int d);
        @(negedge clk);
        wr_en = 1; wr_reg = 2'(r); wr_ch = 2'(ch); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        repeat (n) begin @(negedge clk); if (pwm_o[ch]) hi++; end
    endtask

    task automatic count_evt(input int ch, input bit dma, input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (dma ? dma_req_o[ch] : irq_o[ch]) c++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        idle(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(pwm_o == 0 && irq_o == 0 && dma_req_o == 0, "R1 outputs low", {pwm_o, irq_o, dma_req_o}, 0);
        check(!dz_p_o && dz_n_o, "R1 dead-time pair", {dz_p_o, dz_n_o}, 1);
        chk_on = 1;

        // R3 duty: period 9 (10 ticks), compare 3 (4 high), divider 1:1
        wr(3, 0, 16'h0000);
        wr(0, 1, 9); wr(1, 1, 3); wr(2, 1, 3);
        idle(5);
        count_high(1, 20, v);  check(v == 8, "R3 duty count", v, 8);
        count_evt(1, 0, 20, v); check(v == 2, "R7 irq per period", v, 2);

        // R5 new period applies at reload only: period 4, compare 3
        wr(0, 1, 4);
        idle(15);
        count_high(1, 20, v); check(v == 16, "R5 reloaded duty", v, 16);

        // R6 one-shot stops inactive
        wr(0, 2, 5); wr(1, 2, 5); wr(2, 2, 1);
        count_evt(2, 0, 20, v); check(v == 1, "R6 one-shot single event", v, 1);
        count_high(2, 10, v);   check(v == 0, "R6 parked inactive", v, 0);
        // R4 inversion while idle
        wr(2, 2, 4);
        @(negedge clk); check(pwm_o[2] == 1, "R4 idle inverted", pwm_o[2], 1);

        // R8 external clock, DMA signalling: period 3 -> 4 edges per event
        wr(0, 3, 3); wr(1, 3, 1); wr(2, 3, 16'h1B);
        v = 0;
        repeat (8) begin
            ext_clk_i = 1; repeat (3) begin @(negedge clk); if (dma_req_o[3]) v++; end
            ext_clk_i = 0; repeat (3) begin @(negedge clk); if (dma_req_o[3]) v++; end
        end
        idle(4);
        check(v == 2, "R8 external edge events", v, 2);
        check(irq_o[3] == 0, "R7 dma channel irq quiet", irq_o[3], 0);

        // R2 divider 3, R9 dead time 2 on channel 0
        wr(3, 0, 16'h0202);
        wr(0, 0, 7); wr(1, 0, 3); wr(2, 0, 3);
        idle(30);
        count_evt(0, 0, 48, v); check(v == 2, "R2 divided event rate", v, 2);
        v = 0;
        repeat (48) begin @(negedge clk); if (!dz_p_o && !dz_n_o) v++; end
        check(v > 0, "R9 dead time observed", v, 1);

        // R10 stop by control write with run clear
        wr(2, 0, 0);
        @(negedge clk); check(pwm_o[0] == 0, "R10 stopped output", pwm_o[0], 0);
        count_evt(0, 0, 40, v); check(v == 0, "R10 no events after stop", v, 0);
        // R10 global write ignores channel field
        wr(3, 3, 16'h0000);
        wr(2, 0, 3);
        idle(20);

        chk_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule